// File: doc/BRIEF.md
# Double-Buffered Streaming Bit Interleaver

This block reorders a serial bit stream in fixed-size blocks, for the coded-bit path of an OFDM modem. It holds a block as a matrix of 16 rows. In interleave mode, incoming bits fill the matrix down each column and leave along each row. In deinterleave mode the two orders are exchanged, so a deinterleaver undoes an interleaver that uses the same modulation. The block length follows the selected modulation: 48 subcarriers times the coded bits each carrier carries.

Two storage banks take turns. One bank collects the next block while the other is emitting the previous one, so a continuous input stream gives a continuous output stream with no gap between blocks. Each bank raises its own output valid. The block output valid is the OR of the two, and the output bit comes from the bank that is currently draining. The modulation and mode are taken with the first bit of each block. A shorter block can finish filling while a longer one is still draining. In that case the block stops accepting input until the banks can swap.

Top module: `pingpong_interleaver`

## Requirements
- R1: With deint_mode = 0 and block length N with C = N/16 columns, output bit j of a block equals input bit (j mod C)*16 + floor(j/C) of that block. Input fills columns, and output reads rows.
- R2: With deint_mode = 1, output bit j of a block equals input bit (j mod 16)*C + floor(j/16) of that block. Input fills rows, and output reads columns.
- R3: mod_sel encodes the block length N as follows: 0 gives 48 bits (1 bit per carrier), 1 gives 96 bits (2), 2 gives 192 bits (4) and 3 gives 288 bits (6). A block ends after exactly N accepted bits.
- R4: mod_sel and deint_mode are sampled only on the cycle that accepts the first bit of a block. Changes to them during the rest of the block have no effect on that block.
- R5: When input arrives on every cycle and blocks of equal length follow each other, in_ready stays 1. Output bits then follow on every cycle with no gap at block boundaries.
- R6: out_valid is the OR of the two banks' output valids. At most one bank drives output in any cycle.
- R7: If a block finishes filling while the other bank is still draining, in_ready is 0 from the next cycle until the drain completes and the banks swap. Bits offered while in_ready is 0 are not taken.
- R8: Output is registered. The first bit of a block appears one cycle after the clock edge at which the banks swap. A swap happens at the edge that completes a block when the other bank is idle or is emitting its last bit.
- R9: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| deint_mode | input | 1 | 0 selects interleave, 1 selects deinterleave; sampled with the first bit of a block |
| mod_sel | input | 2 | Modulation code that sets the block length; sampled with the first bit of a block |
| in_valid | input | 1 | in_bit holds a bit offered to the block |
| in_bit | input | 1 | Serial input bit |
| in_ready | output | 1 | The block takes the offered bit on this cycle |
| out_valid | output | 1 | out_bit holds a reordered bit |
| out_bit | output | 1 | Serial output bit |

## Verification
A wrong write or read address shows up as a bit mismatch within one block length of the first bit of the affected block. A wrong block length, or a configuration latched at the wrong moment, shows up at the first block boundary. It appears either as a swap on the wrong cycle, visible through out_valid and in_ready, or as a whole block permuted under the wrong column count. A swap-control fault shows up at once at the ports: in_ready drops during a back-to-back stream, a gap appears between output blocks, or a bit is dropped or doubled. The bench runs a behavioural queue model every clock and compares all three outputs each cycle, so such faults are caught on the first cycle where they differ.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // Largest coded-bits-per-carrier value among the supported modulations.
  localparam int unsigned MAX_BPC = 6;

  typedef enum logic [1:0] {
    MOD_BPSK  = 2'd0,
    MOD_QPSK  = 2'd1,
    MOD_QAM16 = 2'd2,
    MOD_QAM64 = 2'd3
  } mod_e;

  typedef struct packed {
    mod_e mod;
    logic deint;
  } blk_cfg_t;

  function automatic int unsigned bits_per_carrier(mod_e m);
    case (m)
      MOD_BPSK:  bits_per_carrier = 1;
      MOD_QPSK:  bits_per_carrier = 2;
      MOD_QAM16: bits_per_carrier = 4;
      default:   bits_per_carrier = 6;
    endcase
  endfunction

endpackage

// File: rtl/ilv_rst_sync.sv
module ilv_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int unsigned DEPTH = 288,
  parameter int unsigned AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit,
  output logic          rd_vld
);
  logic [DEPTH-1:0] mem_q;
  logic             rd_bit_q;
  logic             rd_vld_q;

  // Storage carries no reset: every location is written before it is read.
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_bit;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_bit_q <= mem_q[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_vld_q <= 1'b0;
    else        rd_vld_q <= rd_en;
  end

  assign rd_bit = rd_bit_q;
  assign rd_vld = rd_vld_q;
endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
  import ilv_pkg::*;
#(
  parameter int unsigned ROWS = 16,
  parameter int unsigned SUBC = 48,
  parameter int unsigned AW   = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          deint_i,
  input  logic [1:0]    mod_i,
  output logic          in_ready,
  output logic          wr_en,
  output logic          wr_bank,
  output logic [AW-1:0] wr_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wcnt,
  output logic [AW-1:0] rcnt,
  output logic [AW-1:0] rsize,
  output blk_cfg_t      wcfg,
  output logic          wr_last,
  output logic          rd_last
);
  localparam logic [AW-1:0] ROWS_W = AW'(ROWS);

  function automatic logic [AW-1:0] size_of(mod_e m);
    size_of = AW'(SUBC * bits_per_carrier(m));
  endfunction

  // Address of matrix cell (idx mod ROWS, idx / ROWS) in row-major storage.
  function automatic logic [AW-1:0] col_walk(logic [AW-1:0] idx, logic [AW-1:0] cols);
    col_walk = AW'((idx % ROWS_W) * cols + (idx / ROWS_W));
  endfunction

  logic          wsel_q, wsel_n;
  logic [AW-1:0] wcnt_q, wcnt_n;
  logic          wfull_q, wfull_n;
  logic          ract_q, ract_n;
  logic [AW-1:0] rcnt_q, rcnt_n;
  blk_cfg_t      wcfg_q, wcfg_n;
  blk_cfg_t      rcfg_q, rcfg_n;

  blk_cfg_t      wcfg_eff;
  logic [AW-1:0] wsize;
  logic          accept, wr_done, rd_free, swap;

  always_comb begin
    wcfg_eff = (wcnt_q == '0) ? blk_cfg_t'{mod: mod_e'(mod_i), deint: deint_i} : wcfg_q;
    wsize    = size_of(wcfg_eff.mod);
    rsize    = size_of(rcfg_q.mod);
    accept   = in_valid && !wfull_q;
    wr_last  = accept && (wcnt_q == wsize - 1'b1);
    wr_done  = wfull_q || wr_last;
    rd_last  = ract_q && (rcnt_q == rsize - 1'b1);
    rd_free  = !ract_q || rd_last;
    swap     = wr_done && rd_free;
    wr_addr  = wcfg_eff.deint ? wcnt_q : col_walk(wcnt_q, wsize / ROWS_W);
    rd_addr  = rcfg_q.deint ? col_walk(rcnt_q, rsize / ROWS_W) : rcnt_q;
  end

  always_comb begin
    wsel_n  = wsel_q;
    wcnt_n  = wcnt_q;
    wfull_n = wfull_q;
    ract_n  = ract_q;
    rcnt_n  = rcnt_q;
    wcfg_n  = wcfg_q;
    rcfg_n  = rcfg_q;
    if (accept) begin
      wcnt_n = wcnt_q + 1'b1;
      if (wcnt_q == '0) wcfg_n = wcfg_eff;
    end
    if (ract_q) rcnt_n = rcnt_q + 1'b1;
    if (rd_last) begin
      ract_n = 1'b0;
      rcnt_n = '0;
    end
    if (swap) begin
      wsel_n  = !wsel_q;
      wcnt_n  = '0;
      wfull_n = 1'b0;
      ract_n  = 1'b1;
      rcnt_n  = '0;
      rcfg_n  = wcfg_eff;
    end else if (wr_last) begin
      wfull_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel_q  <= 1'b0;
      wcnt_q  <= '0;
      wfull_q <= 1'b0;
      ract_q  <= 1'b0;
      rcnt_q  <= '0;
      wcfg_q  <= blk_cfg_t'{mod: MOD_BPSK, deint: 1'b0};
      rcfg_q  <= blk_cfg_t'{mod: MOD_BPSK, deint: 1'b0};
    end else begin
      wsel_q  <= wsel_n;
      wcnt_q  <= wcnt_n;
      wfull_q <= wfull_n;
      ract_q  <= ract_n;
      rcnt_q  <= rcnt_n;
      wcfg_q  <= wcfg_n;
      rcfg_q  <= rcfg_n;
    end
  end

  assign in_ready = !wfull_q;
  assign wr_en    = accept;
  assign wr_bank  = wsel_q;
  assign rd_en    = ract_q;
  assign wcnt     = wcnt_q;
  assign rcnt     = rcnt_q;
  assign wcfg     = wcfg_q;
endmodule

// File: rtl/pingpong_interleaver.sv
module pingpong_interleaver
  import ilv_pkg::*;
#(
  parameter int unsigned ROWS = 16,
  parameter int unsigned SUBC = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       deint_mode,
  input  logic [1:0] mod_sel,
  input  logic       in_valid,
  input  logic       in_bit,
  output logic       in_ready,
  output logic       out_valid,
  output logic       out_bit
);
  localparam int unsigned DEPTH = SUBC * MAX_BPC;
  localparam int unsigned AW    = $clog2(DEPTH + 1);
  localparam int unsigned NBANK = 2;

  logic          srst_n;
  logic          wr_en, wr_bank, rd_en, wr_last, rd_last;
  logic [AW-1:0] wr_addr, rd_addr, wcnt, rcnt, rsize;
  blk_cfg_t      wcfg;
  logic [NBANK-1:0] bank_vld, bank_bit;

  ilv_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ilv_ctrl #(.ROWS(ROWS), .SUBC(SUBC), .AW(AW)) u_ctrl (
    .clk      (clk),
    .rst_n    (srst_n),
    .in_valid (in_valid),
    .deint_i  (deint_mode),
    .mod_i    (mod_sel),
    .in_ready (in_ready),
    .wr_en    (wr_en),
    .wr_bank  (wr_bank),
    .wr_addr  (wr_addr),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .wcnt     (wcnt),
    .rcnt     (rcnt),
    .rsize    (rsize),
    .wcfg     (wcfg),
    .wr_last  (wr_last),
    .rd_last  (rd_last)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ilv_bank #(.DEPTH(DEPTH), .AW(AW)) u_bank (
      .clk     (clk),
      .rst_n   (srst_n),
      .wr_en   (wr_en && (wr_bank == 1'(b))),
      .wr_addr (wr_addr),
      .wr_bit  (in_bit),
      .rd_en   (rd_en && (wr_bank != 1'(b))),
      .rd_addr (rd_addr),
      .rd_bit  (bank_bit[b]),
      .rd_vld  (bank_vld[b])
    );
  end

  assign out_valid = |bank_vld;
  assign out_bit   = |(bank_vld & bank_bit);
endmodule

// File: rtl/ilv_chk.sv
module ilv_chk #(
  parameter int unsigned AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic [1:0]    bank_vld,
  input logic [AW-1:0] wcnt,
  input logic [2:0]    wcfg_bits,
  input logic          rd_en,
  input logic [AW-1:0] rcnt,
  input logic [AW-1:0] rsize,
  input logic          wr_last,
  input logic          rd_last
);
  // R6
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_vld));

  // R7
  stall_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid);

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wcnt != '0) |=> $stable(wcfg_bits));

  // R5
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_last && rd_last) |=> in_ready);

  // R3
  rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rcnt < rsize));
endmodule

bind pingpong_interleaver ilv_chk #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (srst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .bank_vld  (bank_vld),
  .wcnt      (wcnt),
  .wcfg_bits (wcfg),
  .rd_en     (rd_en),
  .rcnt      (rcnt),
  .rsize     (rsize),
  .wr_last   (wr_last),
  .rd_last   (rd_last)
);

// File: tb/pingpong_interleaver_tb_top.sv
module pingpong_interleaver_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       deint_mode = 1'b0;
  logic [1:0] mod_sel = 2'd0;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       in_ready, out_valid, out_bit;

  int unsigned vectors = 0;
  int unsigned fails = 0;
  int unsigned seed = 32'h1234_5678;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  pingpong_interleaver dut_i (
    .clk(clk), .rst_n(rst_n), .deint_mode(deint_mode), .mod_sel(mod_sel),
    .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
    .out_valid(out_valid), .out_bit(out_bit)
  );

  function automatic int blen(logic [1:0] m);
    case (m)
      2'd0: return 48;
      2'd1: return 96;
      2'd2: return 192;
      default: return 288;
    endcase
  endfunction

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  // Behavioural reference model
  bit   wq[$];
  bit   rq[$];
  logic [1:0] m_mod;
  bit   m_deint, m_full, r_deint;
  bit   exp_valid, exp_bit;

  always @(posedge clk) begin
    if (!rst_n) begin
      wq.delete(); rq.delete();
      m_full = 0; exp_valid = 0; exp_bit = 0; r_deint = 0;
    end else begin
      bit acc, done, rd_free;
      if (rq.size() > 0) begin exp_valid = 1; exp_bit = rq.pop_front(); end
      else exp_valid = 0;
      rd_free = (rq.size() == 0);
      acc = in_valid && !m_full;
      if (acc) begin
        if (wq.size() == 0) begin m_mod = mod_sel; m_deint = deint_mode; end
        wq.push_back(in_bit);
      end
      done = m_full || (acc && wq.size() == blen(m_mod));
      if (done && rd_free) begin
        int n, c;
        n = wq.size(); c = n / 16;
        for (int j = 0; j < n; j++) begin
          if (!m_deint) rq.push_back(wq[(j % c) * 16 + j / c]);
          else          rq.push_back(wq[(j % 16) * c + j / 16]);
        end
        r_deint = m_deint;
        wq.delete(); m_full = 0;
      end else if (done) m_full = 1;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      vectors++;
      if (out_valid !== exp_valid) begin
        fails++;
        $display("FAIL R8 R6: out_valid=%0b expected %0b at %0t", out_valid, exp_valid, $time);
      end else if (exp_valid && out_bit !== exp_bit) begin
        fails++;
        $display("FAIL %s R3 R4: out_bit=%0b expected %0b at %0t",
                 r_deint ? "R2" : "R1", out_bit, exp_bit, $time);
      end
      if (in_ready !== !m_full) begin
        fails++;
        $display("FAIL R7 R5: in_ready=%0b expected %0b at %0t", in_ready, !m_full, $time);
      end
    end
  end

  task automatic push(input bit b, input logic [1:0] m, input bit dm);
    bit ok;
    in_valid = 1; in_bit = b; mod_sel = m; deint_mode = dm;
    do begin
      ok = in_ready;
      @(posedge clk); @(negedge clk);
    end while (!ok);
  endtask

  task automatic idle(input int n);
    in_valid = 0;
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic send_block(input logic [1:0] m, input bit dm, input bit gaps, input bit jitter);
    for (int i = 0; i < blen(m); i++) begin
      if (gaps && (rnd() % 4 == 0)) idle(1);
      if (jitter && i > 0) push(rnd() % 2, 2'(rnd() % 4), rnd() % 2);
      else                 push(rnd() % 2, m, dm);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R9: reset state
    vectors++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R9: out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
    end
    // R1 R5 R8: back-to-back interleave blocks
    for (int k = 0; k < 3; k++) send_block(2'd1, 0, 0, 0);
    for (int m = 0; m < 4; m++) begin
      send_block(2'(m), 0, 0, 0);
      send_block(2'(m), 0, 0, 0);
    end
    idle(300);
    // R2 R3: deinterleave at every length
    for (int m = 0; m < 4; m++) begin
      send_block(2'(m), 1, 0, 0);
      send_block(2'(m), 1, 0, 0);
    end
    idle(300);
    // R7: short block completes while a long one drains
    send_block(2'd3, 0, 0, 0);
    send_block(2'd0, 1, 0, 0);
    send_block(2'd0, 0, 0, 0);
    send_block(2'd2, 1, 0, 0);
    idle(300);
    // R4: selects wander during a block
    send_block(2'd2, 0, 0, 1);
    send_block(2'd1, 1, 0, 1);
    send_block(2'd3, 1, 0, 1);
    idle(300);
    // irregular input gaps
    for (int m = 0; m < 4; m++) send_block(2'(m), m % 2, 1, 0);
    idle(400);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule